// File: doc/BRIEF.md
# Transceiver Heartbeat Monitor

Some Ethernet transceivers prove that they are alive by raising their collision line briefly after every frame the MAC has sent. This block watches for that pulse. When the transmit path signals the end of a frame, the monitor opens a fixed listening window and watches the synchronized collision input during it. When the window closes, it writes a status result for the transmit descriptor. If no pulse appeared, the result carries the heartbeat-error flag, which closes the buffer with an error. It also sets a sticky transmit-error event that reaches the interrupt line only when unmasked.

A collision seen inside the window counts as a sign of health and is never reported as a collision error. A collision seen while the monitor is idle is passed on as a collision-error pulse. Checking runs only while the enable input is high. Dropping the enable abandons an open window silently.

The controller has three states. HB_IDLE waits for a frame-done strobe while checking is enabled, then moves to HB_LISTEN. HB_LISTEN moves to HB_HEARD when a synchronized collision is seen. From HB_LISTEN or HB_HEARD, four transitions are possible:
- Window expiry reports the result and returns to HB_IDLE.
- A fresh frame-done strobe reports the result and restarts in HB_LISTEN.
- A low enable returns to HB_IDLE with no report.
- Otherwise the state stays where it is.

Top module: `hb_watch`

## Requirements
- R1: The collision input passes through a two-flop synchronizer, so a level on `col_in` at clock edge k is seen by the monitor at edge k+2. A heartbeat counts only if the monitor sees a collision at one of edges 1 through WIN_CYCLES (default 20), counted after the edge that samples `frame_done` high.
- R2: In the cycle after edge WIN_CYCLES, `stat_wr` is high for exactly one cycle. In that cycle `stat_hb_err` is 1 if no heartbeat was seen and 0 if one was. `stat_hb_err` is never high without `stat_wr`.
- R3: A collision the monitor sees while idle produces a one-cycle `col_err` pulse in the next cycle. A collision seen during an open window never raises `col_err`.
- R4: If `chk_en` is 0 when `frame_done` is sampled, no window opens, and neither `stat_wr` nor `txe_evt` changes. If `chk_en` falls while a window is open, the window is dropped with no report and the monitor returns to idle.
- R5: `txe_evt` is set in the same cycle as a `stat_wr` that has `stat_hb_err` = 1. It stays set until a cycle with `evt_clr` = 1 clears it. When setting and clearing fall on the same edge, the set wins.
- R6: `txe_irq` is high exactly when `txe_evt` is 1 and `txe_mask` is 1 (1 means unmasked). It follows a change of `txe_mask` combinationally.
- R7: A `frame_done` sampled while a window is open ends the current check at that edge. It reports in the next cycle, with `stat_hb_err` = 1 only if no heartbeat has been seen so far. A new full window then starts, counted from that edge.
- R8: While `rst_n` is low, `stat_wr`, `stat_hb_err`, `col_err`, `txe_evt` and `txe_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe at the end of a transmitted frame |
| col_in | input | 1 | Collision line from the transceiver, asynchronous |
| chk_en | input | 1 | Heartbeat checking enable |
| txe_mask | input | 1 | Transmit-error interrupt enable (1 = unmasked) |
| evt_clr | input | 1 | Write-one-to-clear of the transmit-error event |
| stat_wr | output | 1 | Descriptor status write and buffer close strobe |
| stat_hb_err | output | 1 | Heartbeat-error status bit, valid with `stat_wr` |
| col_err | output | 1 | Collision seen outside the heartbeat window |
| txe_evt | output | 1 | Sticky transmit-error event |
| txe_irq | output | 1 | Transmit-error interrupt |

## Verification
The bench builds the monitor with its defaults: a 20-cycle window and a two-stage synchronizer. With those values, every placement of a one-cycle collision pulse relative to the strobe can be tried. The table covers pulses that land just before the window, on its first edge, inside it, on its last edge and one edge past it, so an off-by-one in the counter or the synchronizer depth shows up as a wrong verdict or a misplaced `col_err`. Directed tests then cover the restart-inside-a-window cases, the enable being dropped mid-window, the masked interrupt and set-over-clear on the event bit.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        HB_IDLE   = 2'd0,
        HB_LISTEN = 2'd1,
        HB_HEARD  = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_win_timer.sv
module hb_win_timer #(
    parameter int WIN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (start)            cnt <= '0;
        else if (run && !expire)   cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == LAST);
endmodule

// File: rtl/hb_evt_flag.sv
module hb_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end
endmodule

// File: rtl/hb_watch.sv
module hb_watch
    import hb_pkg::*;
#(
    parameter int WIN_CYCLES  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic col_in,
    input  logic chk_en,
    input  logic txe_mask,
    input  logic evt_clr,
    output logic stat_wr,
    output logic stat_hb_err,
    output logic col_err,
    output logic txe_evt,
    output logic txe_irq
);
    hb_state_e state_q, state_d;
    logic      col_s;
    logic      expire;
    logic      heard;
    logic      rep;
    logic      rep_fail;
    logic      open_win;

    hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (col_in),
        .q     (col_s)
    );

    hb_win_timer #(.WIN(WIN_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (open_win),
        .run    (state_q != HB_IDLE),
        .expire (expire)
    );

    // next state and report decision
    always_comb begin
        state_d  = state_q;
        rep      = 1'b0;
        rep_fail = 1'b0;
        open_win = 1'b0;
        heard    = (state_q == HB_HEARD) || col_s;
        unique case (state_q)
            HB_IDLE: begin
                if (chk_en && frame_done) begin
                    open_win = 1'b1;
                    state_d  = HB_LISTEN;
                end
            end
            HB_LISTEN, HB_HEARD: begin
                if (!chk_en) begin
                    state_d = HB_IDLE;
                end else if (frame_done) begin
                    rep      = 1'b1;
                    rep_fail = !heard;
                    open_win = 1'b1;
                    state_d  = HB_LISTEN;
                end else if (expire) begin
                    rep      = 1'b1;
                    rep_fail = !heard;
                    state_d  = HB_IDLE;
                end else begin
                    state_d  = heard ? HB_HEARD : HB_LISTEN;
                end
            end
            default: state_d = HB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HB_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_wr     <= 1'b0;
            stat_hb_err <= 1'b0;
            col_err     <= 1'b0;
        end else begin
            stat_wr     <= rep;
            stat_hb_err <= rep && rep_fail;
            col_err     <= (state_q == HB_IDLE) && col_s;
        end
    end

    hb_evt_flag u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rep && rep_fail),
        .clr   (evt_clr),
        .q     (txe_evt)
    );

    assign txe_irq = txe_evt && txe_mask;
endmodule

// File: rtl/hb_watch_chk.sv
module hb_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic chk_en,
    input logic evt_clr,
    input logic stat_wr,
    input logic stat_hb_err,
    input logic col_err,
    input logic txe_evt
);
    // R2
    hb_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hb_err |-> stat_wr);

    // R3
    no_col_err_at_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> !col_err);

    // R4
    off_no_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !stat_wr);

    // R5
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_evt && !evt_clr) |=> txe_evt);

    // R5
    evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txe_evt) |-> (stat_wr && stat_hb_err));
endmodule

bind hb_watch hb_watch_chk u_hb_watch_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .evt_clr     (evt_clr),
    .stat_wr     (stat_wr),
    .stat_hb_err (stat_hb_err),
    .col_err     (col_err),
    .txe_evt     (txe_evt)
);

// File: tb/tb_hb_watch.sv
module tb_hb_watch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_done = 1'b0;
    logic col_in = 1'b0;
    logic chk_en = 1'b1;
    logic txe_mask = 1'b1;
    logic evt_clr = 1'b0;
    logic stat_wr, stat_hb_err, col_err, txe_evt, txe_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam int NV = 8;
    // edge index at which col_in is high for one cycle (99 = never)
    localparam int VP [NV] = '{-3, -2, -1, 8, 17, 18, 19, 99};
    // expected heartbeat-error verdict
    localparam bit VF [NV] = '{1, 1, 0, 0, 0, 0, 1, 1};

    always #2 clk = ~clk;

    hb_watch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .col_in      (col_in),
        .chk_en      (chk_en),
        .txe_mask    (txe_mask),
        .evt_clr     (evt_clr),
        .stat_wr     (stat_wr),
        .stat_hb_err (stat_hb_err),
        .col_err     (col_err),
        .txe_evt     (txe_evt),
        .txe_irq     (txe_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic fd, input logic ci);
        frame_done = fd;
        col_in     = ci;
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R8 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R8 stat_wr", stat_wr, 1'b0);
        chk("R8 stat_hb_err", stat_hb_err, 1'b0);
        chk("R8 col_err", col_err, 1'b0);
        chk("R8 txe_evt", txe_evt, 1'b0);
        chk("R8 txe_irq", txe_irq, 1'b0);
        rst_n = 1'b1;
        cyc(0, 0);

        // vector table: R1 window edges, R2 report, R3 col_err, R5/R6 event
        for (int v = 0; v < NV; v++) begin
            for (int i = -3; i <= 24; i++) begin
                cyc(i == 0, i == VP[v]);
                chk("R3 col_err", col_err,
                    (i == VP[v] + 2) && (i <= 0 || i >= 21));
                chk("R2 stat_wr", stat_wr, i == 20);
                if (i == 20) begin
                    chk("R1 stat_hb_err verdict", stat_hb_err, VF[v]);
                    chk("R5 txe_evt set", txe_evt, VF[v]);
                    chk("R6 txe_irq", txe_irq, VF[v]);
                end
            end
            evt_clr = 1'b1;
            cyc(0, 0);
            evt_clr = 1'b0;
            chk("R5 txe_evt cleared", txe_evt, 1'b0);
        end

        // R4 disabled at strobe: no window
        chk_en = 1'b0;
        cyc(1, 0);
        for (int i = 1; i <= 24; i++) begin
            cyc(0, 0);
            chk("R4 disabled stat_wr", stat_wr, 1'b0);
        end
        chk("R4 disabled txe_evt", txe_evt, 1'b0);

        // R4 enable dropped mid-window: abort, back to idle
        chk_en = 1'b1;
        cyc(1, 0);
        for (int i = 1; i <= 4; i++) cyc(0, 0);
        chk_en = 1'b0;
        for (int i = 5; i <= 26; i++) begin
            cyc(0, 0);
            chk("R4 abort stat_wr", stat_wr, 1'b0);
        end
        chk("R4 abort txe_evt", txe_evt, 1'b0);
        chk_en = 1'b1;
        cyc(0, 1);
        cyc(0, 0);
        cyc(0, 0);
        chk("R4 idle after abort col_err", col_err, 1'b1);
        cyc(0, 0);

        // R6 masked failure, then unmask
        txe_mask = 1'b0;
        cyc(1, 0);
        for (int i = 1; i <= 20; i++) cyc(0, 0);
        chk("R2 masked stat_wr", stat_wr, 1'b1);
        chk("R2 masked stat_hb_err", stat_hb_err, 1'b1);
        chk("R5 masked txe_evt", txe_evt, 1'b1);
        chk("R6 masked txe_irq", txe_irq, 1'b0);
        for (int i = 0; i < 5; i++) cyc(0, 0);
        chk("R5 sticky txe_evt", txe_evt, 1'b1);
        txe_mask = 1'b1;
        #1;
        chk("R6 unmasked txe_irq", txe_irq, 1'b1);

        // R5 set wins over clear on the same edge
        evt_clr = 1'b1;
        cyc(1, 0);
        chk("R5 clear txe_evt", txe_evt, 1'b0);
        for (int i = 1; i <= 20; i++) cyc(0, 0);
        chk("R5 set over clear", txe_evt, 1'b1);
        cyc(0, 0);
        chk("R5 clear after", txe_evt, 1'b0);
        evt_clr = 1'b0;

        // R7 restart without heartbeat, then pass in new window
        cyc(1, 0);
        for (int i = 1; i <= 30; i++) begin
            cyc(i == 10, i == 12);
            chk("R7 restart stat_wr", stat_wr, (i == 10) || (i == 30));
            if (i == 10) chk("R7 restart fail verdict", stat_hb_err, 1'b1);
            if (i == 30) chk("R7 new window pass", stat_hb_err, 1'b0);
            chk("R3 in-window col_err", col_err, 1'b0);
        end
        evt_clr = 1'b1;
        cyc(0, 0);
        evt_clr = 1'b0;

        // R7 restart after heartbeat, then fail in new window
        cyc(1, 0);
        for (int i = 1; i <= 30; i++) begin
            cyc(i == 10, i == 3);
            chk("R7 heard stat_wr", stat_wr, (i == 10) || (i == 30));
            if (i == 10) chk("R7 heard pass verdict", stat_hb_err, 1'b0);
            if (i == 10) chk("R5 no event on pass", txe_evt, 1'b0);
            if (i == 30) chk("R7 new window fail", stat_hb_err, 1'b1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule